// File: doc/BRIEF.md
# Write-Masked Control Register Pair

This block keeps a 64-bit control word together with a 64-bit protection word. Each bit set in the protection word pins the matching control bit at its present value whenever software writes the control word. Bits left clear in the protection word let the written value through. Software reaches both words through one request port. Each request carries a privilege level from 0 to 3 and a one-bit target select. A read returns its data combinationally in the cycle of the request. A refused request changes nothing, and one cycle later it produces a single-cycle `rsp_undef` pulse.

The protection word guards itself. At level 2 it can be written only while it is entirely zero, so the first non-zero value written there locks it. Level 3 may rewrite it at any time, including clearing it, and a cleared word unlocks it again for level 2. Level 0 has no access to either word. Seven positions (bits 49, 48, 47, 41, 39, 17 and 9) are reserved. In both words they read as zero and take no value from a write. Both live words are exported so that neighbouring logic can use the control bits directly.

Top module: `wmreg_pair`

## Requirements
- R1: After a synchronous reset both words are zero and `rsp_undef` is low.
- R2: A granted control write stores, for every bit, the old bit where the protection bit is 1 and the written bit where it is 0. The result is visible on `ctrl_value` after the clock edge that accepts the write.
- R3: Reserved bits 49, 48, 47, 41, 39, 17 and 9 read as 0 in both words, whatever is written to them.
- R4: A level-2 write to the protection word (`req_target`=1) is granted while the protection word is all zero.
- R5: A level-2 write to the protection word is refused while that word is non-zero, and the word keeps its value.
- R6: A level-3 write to the protection word is always granted, whatever its current value, and writing zero unlocks it for level 2.
- R7: Any request at level 0 (`req_priv`=0), read or write, is refused and changes no state. A refused read returns zero data.
- R8: `rsp_undef` is high for exactly the one cycle after a refused request. It stays low after granted requests and idle cycles.
- R9: A read at level 1 to 3 returns the selected word (`req_target` 0 = control, 1 = protection) on `rsp_rdata` in the cycle of the request. `rsp_rdata` is zero when no read is granted.
- R10: A level-1 write to the protection word is refused. A level-1 control write is granted, subject to R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Privilege level of the request, 0..3 |
| req_target | input | 1 | 0 = control word, 1 = protection word |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, same cycle as the request |
| rsp_undef | output | 1 | One-cycle pulse after a refused request |
| ctrl_value | output | 64 | Current control word |
| mask_value | output | 64 | Current protection word |

## Verification
Two events can fall in the same cycle: the error pulse left by a refused request, and the combinational read data of the next request. The bench refuses a level-2 write to a locked protection word and issues a read in the very next cycle. In that single cycle it judges that `rsp_undef` is high and that `rsp_rdata` still shows the unchanged protection word. A second overlap is a protection-word write followed directly by a control write. That control write must already obey the new protection bits.

// File: rtl/wmreg_pkg.sv
package wmreg_pkg;

    localparam int unsigned WORD_W = 64;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_HYP   = 2'd2,
        PRIV_MON   = 2'd3
    } priv_e;

    typedef enum logic {
        TGT_CTRL = 1'b0,
        TGT_MASK = 1'b1
    } target_e;

    typedef struct packed {
        logic    valid;
        logic    write;
        priv_e   priv;
        target_e target;
    } req_s;

    typedef struct packed {
        logic rd_ok;
        logic wr_ctrl;
        logic wr_mask;
        logic refuse;
    } grant_s;

    // Reserved positions of the default 64-bit layout.
    function automatic logic [WORD_W-1:0] default_resv();
        logic [WORD_W-1:0] r;
        r = '0;
        for (int b = 47; b <= 49; b++) r[b] = 1'b1;
        r[41] = 1'b1;
        r[39] = 1'b1;
        r[17] = 1'b1;
        r[9]  = 1'b1;
        return r;
    endfunction

    // May this level rewrite the protection word given its present state?
    function automatic logic mask_write_allowed(priv_e lvl, logic mask_nonzero);
        logic ok;
        case (lvl)
            PRIV_MON: ok = 1'b1;
            PRIV_HYP: ok = !mask_nonzero;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/wmreg_access_ctl.sv
module wmreg_access_ctl
    import wmreg_pkg::*;
(
    input  req_s   req,
    input  logic   mask_nonzero,
    output grant_s grant
);
    logic user_level;
    logic mask_denied;

    always_comb begin
        user_level  = (req.priv == PRIV_USER);
        mask_denied = req.write && (req.target == TGT_MASK)
                      && !mask_write_allowed(req.priv, mask_nonzero);

        grant.refuse  = req.valid && (user_level || mask_denied);
        grant.rd_ok   = req.valid && !req.write && !grant.refuse;
        grant.wr_ctrl = req.valid && req.write && (req.target == TGT_CTRL) && !grant.refuse;
        grant.wr_mask = req.valid && req.write && (req.target == TGT_MASK) && !grant.refuse;
    end
endmodule

// File: rtl/wmreg_mask_reg.sv
module wmreg_mask_reg #(
    parameter int unsigned       DATA_W    = 64,
    parameter logic [DATA_W-1:0] RESV_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              nonzero
);
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)     word_q <= '0;
        else if (we) word_q <= wdata & ~RESV_MASK;
    end

    assign value   = word_q;
    assign nonzero = |word_q;
endmodule

// File: rtl/wmreg_ctrl_reg.sv
module wmreg_ctrl_reg #(
    parameter int unsigned       DATA_W    = 64,
    parameter logic [DATA_W-1:0] RESV_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] protect,
    output logic [DATA_W-1:0] value
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (RESV_MASK[i]) begin : g_resv
            assign value[i] = 1'b0;
        end else begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)                   bit_q <= 1'b0;
                else if (we && !protect[i]) bit_q <= wdata[i];
            end
            assign value[i] = bit_q;
        end
    end
endmodule

// File: rtl/wmreg_pair.sv
module wmreg_pair
    import wmreg_pkg::*;
#(
    parameter int unsigned       DATA_W    = WORD_W,
    parameter logic [DATA_W-1:0] RESV_MASK = DATA_W'(default_resv())
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_priv,
    input  logic              req_target,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_undef,
    output logic [DATA_W-1:0] ctrl_value,
    output logic [DATA_W-1:0] mask_value
);
    req_s   req;
    grant_s grant;
    logic   mask_nonzero;
    logic   undef_q;

    assign req.valid  = req_valid;
    assign req.write  = req_write;
    assign req.priv   = priv_e'(req_priv);
    assign req.target = target_e'(req_target);

    wmreg_access_ctl u_access (
        .req          (req),
        .mask_nonzero (mask_nonzero),
        .grant        (grant)
    );

    wmreg_mask_reg #(.DATA_W(DATA_W), .RESV_MASK(RESV_MASK)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .we      (grant.wr_mask),
        .wdata   (req_wdata),
        .value   (mask_value),
        .nonzero (mask_nonzero)
    );

    wmreg_ctrl_reg #(.DATA_W(DATA_W), .RESV_MASK(RESV_MASK)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (grant.wr_ctrl),
        .wdata   (req_wdata),
        .protect (mask_value),
        .value   (ctrl_value)
    );

    always_comb begin
        rsp_rdata = '0;
        if (grant.rd_ok)
            rsp_rdata = (req.target == TGT_MASK) ? mask_value : ctrl_value;
    end

    always_ff @(posedge clk) begin
        if (rst) undef_q <= 1'b0;
        else     undef_q <= grant.refuse;
    end

    assign rsp_undef = undef_q;
endmodule

// File: rtl/wmreg_pair_chk.sv
module wmreg_pair_chk #(
    parameter int unsigned       DATA_W    = 64,
    parameter logic [DATA_W-1:0] RESV_MASK = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_priv,
    input logic              req_target,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_undef,
    input logic [DATA_W-1:0] ctrl_value,
    input logic [DATA_W-1:0] mask_value
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r3_resv_zero: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_value & RESV_MASK) == '0) && ((mask_value & RESV_MASK) == '0));

    a_r2_frozen_bits: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (((ctrl_value ^ $past(ctrl_value)) & $past(mask_value)) == '0));

    a_r5_locked_mask: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(mask_value) != '0 && $past(req_valid && req_write && req_target && req_priv == 2'd2))
        |-> ($stable(mask_value) && rsp_undef));

    a_r6_top_write: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(req_valid && req_write && req_target && req_priv == 2'd3))
        |-> (mask_value == ($past(req_wdata) & ~RESV_MASK)));

    a_r7_user_refused: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(req_valid && req_priv == 2'd0))
        |-> (rsp_undef && $stable(ctrl_value) && $stable(mask_value)));

    a_r8_undef_cause: assert property (@(posedge clk) disable iff (rst)
        rsp_undef |-> (past_ok && $past(req_valid)));
endmodule

bind wmreg_pair wmreg_pair_chk #(.DATA_W(DATA_W), .RESV_MASK(RESV_MASK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_priv   (req_priv),
    .req_target (req_target),
    .req_wdata  (req_wdata),
    .rsp_undef  (rsp_undef),
    .ctrl_value (ctrl_value),
    .mask_value (mask_value)
);

// File: tb/wmreg_pair_test.sv
module wmreg_pair_test;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_write, req_target;
    logic [1:0]   req_priv;
    logic [W-1:0] req_wdata;
    logic [W-1:0] rsp_rdata, ctrl_value, mask_value;
    logic         rsp_undef;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] resv;
    logic [W-1:0] m_ctrl, m_mask;
    logic [W-1:0] got_rd;
    logic         got_undef;

    always #4 clk = ~clk;

    wmreg_pair uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_target(req_target), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef),
        .ctrl_value(ctrl_value), .mask_value(mask_value)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at negedge, capture read data mid-cycle, pass one posedge,
    // then capture the registered error at the following negedge.
    task automatic issue(input logic wr, input logic [1:0] lvl, input logic tgt,
                         input logic [W-1:0] data);
        req_valid = 1'b1; req_write = wr; req_priv = lvl; req_target = tgt; req_wdata = data;
        #1 got_rd = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
        got_undef = rsp_undef;
    endtask

    task automatic t_reset;
        chk("R1 ctrl", ctrl_value, '0);
        chk("R1 mask", mask_value, '0);
        chk("R1 undef", {63'd0, rsp_undef}, '0);
    endtask

    task automatic t_open_ctrl;
        issue(1'b1, 2'd1, 1'b0, {W{1'b1}});
        m_ctrl = ~resv;
        chk("R2/R10 level1 ctrl write", ctrl_value, m_ctrl);
        chk("R3 ctrl reserved zero", ctrl_value & resv, '0);
        chk("R8 no undef on grant", {63'd0, got_undef}, '0);
        issue(1'b1, 2'd3, 1'b0, 64'h5555_5555_5555_5555);
        m_ctrl = 64'h5555_5555_5555_5555 & ~resv;
        issue(1'b0, 2'd1, 1'b0, '0);
        chk("R9 read ctrl", got_rd, m_ctrl);
    endtask

    task automatic t_mask_then_ctrl;
        logic [W-1:0] nv;
        issue(1'b1, 2'd2, 1'b1, 64'h0002_0000_0000_00FF | resv);
        m_mask = 64'h0002_0000_0000_00FF & ~resv;
        chk("R4 level2 mask write", mask_value, m_mask);
        chk("R3 mask reserved zero", mask_value & resv, '0);
        // control write right after the mask write
        nv = 64'hAAAA_AAAA_AAAA_AAAA;
        issue(1'b1, 2'd1, 1'b0, nv);
        m_ctrl = ((m_ctrl & m_mask) | (nv & ~m_mask)) & ~resv;
        chk("R2 frozen merge", ctrl_value, m_ctrl);
        issue(1'b0, 2'd2, 1'b1, '0);
        chk("R9 read mask", got_rd, m_mask);
    endtask

    task automatic t_locked;
        // refused write, then read in the very next cycle
        req_valid = 1'b1; req_write = 1'b1; req_priv = 2'd2; req_target = 1'b1; req_wdata = '0;
        @(negedge clk);
        req_write = 1'b0; req_priv = 2'd1; req_target = 1'b1;
        #1;
        chk("R5 undef on locked write", {63'd0, rsp_undef}, 64'd1);
        chk("R9 same-cycle read while undef", rsp_rdata, m_mask);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 undef one cycle only", {63'd0, rsp_undef}, '0);
        chk("R5 mask kept", mask_value, m_mask);
        issue(1'b1, 2'd1, 1'b1, '0);
        chk("R10 level1 mask write refused", {63'd0, got_undef}, 64'd1);
        chk("R10 mask unchanged", mask_value, m_mask);
    endtask

    task automatic t_user;
        issue(1'b1, 2'd0, 1'b0, '0);
        chk("R7 user write undef", {63'd0, got_undef}, 64'd1);
        chk("R7 ctrl unchanged", ctrl_value, m_ctrl);
        issue(1'b0, 2'd0, 1'b0, '0);
        chk("R7 user read zero", got_rd, '0);
        chk("R7 user read undef", {63'd0, got_undef}, 64'd1);
        issue(1'b1, 2'd0, 1'b1, '0);
        chk("R7 mask unchanged", mask_value, m_mask);
    endtask

    task automatic t_top;
        issue(1'b1, 2'd3, 1'b1, 64'hDEAD_BEEF_0123_4567);
        m_mask = 64'hDEAD_BEEF_0123_4567 & ~resv;
        chk("R6 top overwrites locked mask", mask_value, m_mask);
        chk("R6 no undef", {63'd0, got_undef}, '0);
        issue(1'b1, 2'd3, 1'b1, '0);
        m_mask = '0;
        chk("R6 top clears mask", mask_value, '0);
        issue(1'b1, 2'd2, 1'b1, 64'h1);
        m_mask = 64'h1;
        chk("R6 level2 unlocked again", mask_value, m_mask);
        issue(1'b0, 2'd2, 1'b1, '0);
        chk("R8 no undef after read", {63'd0, got_undef}, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        resv = '0;
        resv[49] = 1'b1; resv[48] = 1'b1; resv[47] = 1'b1;
        resv[41] = 1'b1; resv[39] = 1'b1; resv[17] = 1'b1; resv[9] = 1'b1;
        m_ctrl = '0; m_mask = '0;
        req_valid = 1'b0; req_write = 1'b0; req_priv = 2'd0; req_target = 1'b0; req_wdata = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_open_ctrl();
        t_mask_then_ctrl();
        t_locked();
        t_user();
        t_top();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule